// File: doc/BRIEF.md
# Precise Trap Commit Controller

This block is the control spine of an in-order pipeline that has exactly one finalize (result-store) stage. It carries the tags of every instruction in flight: a valid bit, the instruction address, a trap flag and a four-bit cause code. An earlier stage that finds a fault does not redirect anything itself. It marks the instruction's outgoing tag with the trap flag and cause, and the stages behind it freeze until the marked instruction reaches the finalize stage.

Only the finalize stage starts trap or interrupt entry. In that single cycle it withholds the writeback of the instruction there, discards every younger instruction, loads the instruction's address and the cause into two special registers, and points fetch at the handler vector. An external interrupt request uses the same path. It aborts the instruction that was about to commit and saves that instruction's address, so the handler always sees the machine state as of the boundary just before one definite instruction.

Top module: `ptc_ctrl`

## Requirements
- R1: After reset no instruction is in flight: wb_valid and redir_valid are low, in_ready is high, stage_hold is zero, and epc and cause read zero.
- R2: Without traps or interrupts, an address accepted on the fetch port in cycle n commits (wb_valid high, wb_pc equal to that address) in cycle n+NSTAGE, and commits follow acceptance order.
- R3: Raising det_trap[k] in cycle n while stage k holds an instruction has no immediate effect on commit. Entry for that instruction happens in cycle n+NSTAGE-1-k, and all older instructions commit normally first.
- R4: While a flagged instruction sits in stage m (m >= 1), stage_hold bits 0 to m-1 are high and in_ready is low.
- R5: In the cycle a flagged instruction is in the finalize stage, wb_valid is low, redir_valid is high and redir_pc equals TRAP_VEC.
- R6: One cycle after entry, epc holds the aborted instruction's address and cause holds its code. The codes are 1 divide by zero, 2 overflow, 3 illegal opcode, 4 bad address and 8 external interrupt.
- R7: Entry discards every younger instruction: with no new fetches, wb_valid stays low after the entry cycle.
- R8: When more than one instruction carries a trap flag, the oldest is taken and the younger ones are discarded, even if a younger one was flagged first.
- R9: With irq high and an unflagged instruction in the finalize stage, that instruction does not commit. redir_pc equals IRQ_VEC, and epc and cause become its address and 8.
- R10: irq while the finalize stage is empty has no effect.
- R11: When a flagged instruction is at the finalize stage while irq is high, trap entry is taken with the trap's own cause and TRAP_VEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetch presents an instruction |
| in_pc | input | PC_W | Address of the presented instruction |
| in_ready | output | 1 | First stage accepts this cycle |
| det_trap | input | NSTAGE-1 | Per-stage fault detection, bit k for stage k |
| det_cause | input | (NSTAGE-1)*4 | Per-stage cause code, 4 bits per stage |
| irq | input | 1 | External interrupt request, level |
| wb_valid | output | 1 | Finalize stage commits this cycle |
| wb_pc | output | PC_W | Address of the instruction in finalize |
| redir_valid | output | 1 | Trap or interrupt entry this cycle |
| redir_pc | output | PC_W | Handler vector for the entry |
| epc | output | PC_W | Saved address of the aborted instruction |
| cause | output | 4 | Saved cause code |
| stage_hold | output | NSTAGE-1 | Per-stage freeze, bit k for stage k |

## Verification
A continuous stream of sequential addresses is run through the pipe while faults are injected at each depth. The patterns are a fault in the first stage on the very first instruction, a mid-pipe fault, and a fault one stage before finalize. These separate a flag that travels from one that acts on the spot, and check that the freeze mask widens with depth. Two faults raised in the same cycle, and a younger fault raised before an older one, separate oldest-first selection from first-raised selection. Interrupt pulses are applied while finalize is empty, while it is occupied, and in the same cycle as a trap arrival. These tell apart waiting, aborting the committing instruction, and trap priority.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  localparam int CAUSE_W = 4;
  typedef logic [CAUSE_W-1:0] cause_t;

  localparam cause_t CAUSE_NONE    = 4'h0;
  localparam cause_t CAUSE_DIV0    = 4'h1;
  localparam cause_t CAUSE_OVF     = 4'h2;
  localparam cause_t CAUSE_ILLEGAL = 4'h3;
  localparam cause_t CAUSE_BADADDR = 4'h4;
  localparam cause_t CAUSE_EXTIRQ  = 4'h8;

  // The first fault seen by an instruction wins; later detections keep it.
  function automatic cause_t pick_cause(logic already, cause_t held, cause_t fresh);
    return already ? held : fresh;
  endfunction

  // Handler selection at the finalize stage.
  function automatic logic [63:0] pick_vector(logic is_trap, logic [63:0] tvec,
                                              logic [63:0] ivec);
    return is_trap ? tvec : ivec;
  endfunction

endpackage

// File: rtl/ptc_slot.sv
module ptc_slot
  import ptc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            hold,
  input  logic            src_valid,
  input  logic [PC_W-1:0] src_pc,
  input  logic            src_trap,
  input  cause_t          src_cause,
  output logic            q_valid,
  output logic [PC_W-1:0] q_pc,
  output logic            q_trap,
  output cause_t          q_cause
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_pc    <= '0;
      q_trap  <= 1'b0;
      q_cause <= CAUSE_NONE;
    end else if (flush) begin
      q_valid <= 1'b0;
      q_trap  <= 1'b0;
    end else if (!hold) begin
      q_valid <= src_valid;
      q_pc    <= src_pc;
      q_trap  <= src_valid & src_trap;
      q_cause <= src_cause;
    end
  end

endmodule

// File: rtl/ptc_hazard.sv
module ptc_hazard #(
  parameter int NSTAGE = 5,
  localparam int NDET = NSTAGE - 1
) (
  // bit b: stage b+1 holds a flagged instruction
  input  logic [NDET-1:0] flag_above,
  // bit b: stage b must freeze
  output logic [NDET-1:0] hold
);

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int b = NDET - 1; b >= 0; b--) begin
      acc     = acc | flag_above[b];
      hold[b] = acc;
    end
  end

endmodule

// File: rtl/ptc_commit.sv
module ptc_commit
  import ptc_pkg::*;
#(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] TRAP_VEC = 'h100,
  parameter logic [PC_W-1:0] IRQ_VEC  = 'h200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fin_valid,
  input  logic            fin_trap,
  input  cause_t          fin_cause,
  input  logic [PC_W-1:0] fin_pc,
  input  logic            irq,
  output logic            wb_valid,
  output logic            take_trap,
  output logic            take_irq,
  output logic            flush,
  output logic [PC_W-1:0] redir_pc,
  output logic [PC_W-1:0] epc,
  output cause_t          cause
);

  cause_t    ent_cause;
  logic [63:0] vec64;

  always_comb begin
    take_trap = fin_valid & fin_trap;
    take_irq  = fin_valid & ~fin_trap & irq;
    flush     = take_trap | take_irq;
    wb_valid  = fin_valid & ~flush;
    ent_cause = take_trap ? fin_cause : CAUSE_EXTIRQ;
    vec64     = pick_vector(take_trap, 64'(TRAP_VEC), 64'(IRQ_VEC));
    redir_pc  = vec64[PC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= CAUSE_NONE;
    end else if (flush) begin
      epc   <= fin_pc;
      cause <= ent_cause;
    end
  end

endmodule

// File: rtl/ptc_ctrl.sv
module ptc_ctrl
  import ptc_pkg::*;
#(
  parameter int NSTAGE = 5,
  parameter int PC_W   = 32,
  parameter logic [PC_W-1:0] TRAP_VEC = 'h100,
  parameter logic [PC_W-1:0] IRQ_VEC  = 'h200,
  localparam int NDET = NSTAGE - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [PC_W-1:0]         in_pc,
  output logic                    in_ready,
  input  logic [NDET-1:0]         det_trap,
  input  logic [NDET*CAUSE_W-1:0] det_cause,
  input  logic                    irq,
  output logic                    wb_valid,
  output logic [PC_W-1:0]         wb_pc,
  output logic                    redir_valid,
  output logic [PC_W-1:0]         redir_pc,
  output logic [PC_W-1:0]         epc,
  output logic [CAUSE_W-1:0]      cause,
  output logic [NDET-1:0]         stage_hold
);

  localparam int FIN = NSTAGE - 1;

  logic [NSTAGE-1:0] cur_valid, cur_trap, src_valid, src_trap, hold_v;
  logic [PC_W-1:0]   cur_pc  [NSTAGE];
  logic [PC_W-1:0]   src_pc  [NSTAGE];
  cause_t            cur_cause [NSTAGE];
  cause_t            src_cause [NSTAGE];
  logic [NDET-1:0]   flag_above, hold_det;

  // named events for the checker
  logic fin_valid, fin_trap, take_trap, take_irq, flush;

  genvar j;
  generate
    for (j = 0; j < NSTAGE; j++) begin : g_stage
      if (j == 0) begin : g_src_fetch
        assign src_valid[j] = in_valid;
        assign src_pc[j]    = in_pc;
        assign src_trap[j]  = 1'b0;
        assign src_cause[j] = CAUSE_NONE;
      end else begin : g_src_prev
        assign src_valid[j] = cur_valid[j-1] & ~hold_v[j-1];
        assign src_pc[j]    = cur_pc[j-1];
        assign src_trap[j]  = cur_trap[j-1] | det_trap[j-1];
        assign src_cause[j] = pick_cause(cur_trap[j-1], cur_cause[j-1],
                                         det_cause[(j-1)*CAUSE_W +: CAUSE_W]);
      end

      ptc_slot #(.PC_W(PC_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .hold      (hold_v[j]),
        .src_valid (src_valid[j]),
        .src_pc    (src_pc[j]),
        .src_trap  (src_trap[j]),
        .src_cause (src_cause[j]),
        .q_valid   (cur_valid[j]),
        .q_pc      (cur_pc[j]),
        .q_trap    (cur_trap[j]),
        .q_cause   (cur_cause[j])
      );
    end

    for (j = 0; j < NDET; j++) begin : g_flag
      assign flag_above[j] = cur_valid[j+1] & cur_trap[j+1];
    end
  endgenerate

  ptc_hazard #(.NSTAGE(NSTAGE)) u_hazard (
    .flag_above (flag_above),
    .hold       (hold_det)
  );

  assign hold_v    = {1'b0, hold_det};
  assign fin_valid = cur_valid[FIN];
  assign fin_trap  = cur_trap[FIN];

  ptc_commit #(.PC_W(PC_W), .TRAP_VEC(TRAP_VEC), .IRQ_VEC(IRQ_VEC)) u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .fin_valid (fin_valid),
    .fin_trap  (fin_trap),
    .fin_cause (cur_cause[FIN]),
    .fin_pc    (cur_pc[FIN]),
    .irq       (irq),
    .wb_valid  (wb_valid),
    .take_trap (take_trap),
    .take_irq  (take_irq),
    .flush     (flush),
    .redir_pc  (redir_pc),
    .epc       (epc),
    .cause     (cause)
  );

  assign wb_pc       = cur_pc[FIN];
  assign redir_valid = flush;
  assign in_ready    = ~hold_v[0] & ~flush;
  assign stage_hold  = hold_det;

endmodule

// File: rtl/ptc_ctrl_chk.sv
module ptc_ctrl_chk #(
  parameter int NDET = 4,
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] TRAP_VEC = 'h100
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq,
  input logic            in_ready,
  input logic            wb_valid,
  input logic            redir_valid,
  input logic [PC_W-1:0] redir_pc,
  input logic [NDET-1:0] stage_hold,
  input logic [3:0]      cause,
  input logic            fin_valid,
  input logic            fin_trap
);

  p_freeze_blocks_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|stage_hold) |-> !in_ready);

  p_entry_no_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !wb_valid);

  p_trap_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_valid && fin_trap) |-> (redir_valid && redir_pc == TRAP_VEC));

  p_cause_loaded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (cause != 4'h0));

  p_pipe_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (!wb_valid && stage_hold == '0));

  p_irq_waits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !fin_valid) |-> !redir_valid);

  p_trap_beats_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && fin_valid && fin_trap) |-> (redir_pc == TRAP_VEC));

endmodule

bind ptc_ctrl ptc_ctrl_chk #(
  .NDET(NSTAGE - 1), .PC_W(PC_W), .TRAP_VEC(TRAP_VEC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq         (irq),
  .in_ready    (in_ready),
  .wb_valid    (wb_valid),
  .redir_valid (redir_valid),
  .redir_pc    (redir_pc),
  .stage_hold  (stage_hold),
  .cause       (cause),
  .fin_valid   (fin_valid),
  .fin_trap    (fin_trap)
);

// File: tb/ptc_ctrl_bench.sv
module ptc_ctrl_bench;

  localparam int NS = 5;
  localparam int PCW = 32;
  localparam logic [31:0] TV = 32'h100;
  localparam logic [31:0] IV = 32'h200;
  localparam logic [31:0] BASE = 32'h1000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, in_valid, in_ready, irq, wb_valid, redir_valid;
  logic [31:0] in_pc, wb_pc, redir_pc, epc;
  logic [3:0] det_trap, stage_hold, cause;
  logic [15:0] det_cause;

  ptc_ctrl #(.NSTAGE(NS), .PC_W(PCW), .TRAP_VEC(TV), .IRQ_VEC(IV)) u_ptc_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
    .in_ready(in_ready), .det_trap(det_trap), .det_cause(det_cause),
    .irq(irq), .wb_valid(wb_valid), .wb_pc(wb_pc), .redir_valid(redir_valid),
    .redir_pc(redir_pc), .epc(epc), .cause(cause), .stage_hold(stage_hold)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic       d1_en;  logic [7:0] d1_cyc; logic [2:0] d1_stg; logic [3:0] d1_cau;
    logic       d2_en;  logic [7:0] d2_cyc; logic [2:0] d2_stg; logic [3:0] d2_cau;
    logic       irq_en; logic [7:0] irq_lo; logic [7:0] irq_hi;
    logic       exp_redir; logic exp_trap;
    logic [7:0] exp_commits; logic [7:0] exp_epc; logic [3:0] exp_cause;
    logic [7:0] end_cyc;
  } scen_t;

  localparam int NSCN = 9;
  localparam scen_t SCN [NSCN] = '{
    // mid-pipe divide-by-zero
    '{1'b1, 8'd6, 3'd2, 4'd1,  1'b0, 8'd0, 3'd0, 4'd0,  1'b0, 8'd0, 8'd0,
      1'b1, 1'b1, 8'd3, 8'd3, 4'd1, 8'd30},
    // first stage, first instruction, bad address
    '{1'b1, 8'd1, 3'd0, 4'd4,  1'b0, 8'd0, 3'd0, 4'd0,  1'b0, 8'd0, 8'd0,
      1'b1, 1'b1, 8'd0, 8'd0, 4'd4, 8'd30},
    // last detect stage, illegal opcode
    '{1'b1, 8'd10, 3'd3, 4'd3, 1'b0, 8'd0, 3'd0, 4'd0,  1'b0, 8'd0, 8'd0,
      1'b1, 1'b1, 8'd6, 8'd6, 4'd3, 8'd30},
    // two faults same cycle, older deeper
    '{1'b1, 8'd8, 3'd3, 4'd2,  1'b1, 8'd8, 3'd1, 4'd3,  1'b0, 8'd0, 8'd0,
      1'b1, 1'b1, 8'd4, 8'd4, 4'd2, 8'd30},
    // younger flagged first, older flagged later
    '{1'b1, 8'd5, 3'd0, 4'd1,  1'b1, 8'd7, 3'd3, 4'd4,  1'b0, 8'd0, 8'd0,
      1'b1, 1'b1, 8'd3, 8'd3, 4'd4, 8'd30},
    // interrupt with occupied finalize
    '{1'b0, 8'd0, 3'd0, 4'd0,  1'b0, 8'd0, 3'd0, 4'd0,  1'b1, 8'd7, 8'd7,
      1'b1, 1'b0, 8'd2, 8'd2, 4'd8, 8'd30},
    // trap and interrupt meet at finalize
    '{1'b1, 8'd6, 3'd2, 4'd2,  1'b0, 8'd0, 3'd0, 4'd0,  1'b1, 8'd8, 8'd8,
      1'b1, 1'b1, 8'd3, 8'd3, 4'd2, 8'd30},
    // interrupt pulse while finalize empty
    '{1'b0, 8'd0, 3'd0, 4'd0,  1'b0, 8'd0, 3'd0, 4'd0,  1'b1, 8'd2, 8'd3,
      1'b0, 1'b0, 8'd8, 8'd0, 4'd0, 8'd12},
    // interrupt held until first instruction arrives
    '{1'b0, 8'd0, 3'd0, 4'd0,  1'b0, 8'd0, 3'd0, 4'd0,  1'b1, 8'd2, 8'd5,
      1'b1, 1'b0, 8'd0, 8'd0, 4'd8, 8'd30}
  };

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_pc = '0; det_trap = '0; det_cause = '0; irq = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_scn(input int s);
    scen_t sc;
    int fcount, commits, seq_bad, first_wb, redir_cyc, hold_cyc, exp_cyc, a1, a2, quiet;
    logic [31:0] rpc;
    logic [3:0] mask;
    bit got;
    sc = SCN[s];
    fcount = 0; commits = 0; seq_bad = 0; first_wb = -1; redir_cyc = -1;
    quiet = 0; rpc = '0; got = 0;
    hold_cyc = sc.d1_en ? int'(sc.d1_cyc) + 1 : -1;
    mask = 4'((5'd1 << (int'(sc.d1_stg) + 1)) - 5'd1);
    do_reset();
    for (int n = 0; n <= int'(sc.end_cyc) && !got; n++) begin
      in_valid = 1'b1;
      in_pc = BASE + 32'(4 * fcount);
      det_trap = '0; det_cause = '0;
      if (sc.d1_en && n == int'(sc.d1_cyc)) begin
        det_trap[sc.d1_stg] = 1'b1; det_cause[sc.d1_stg*4 +: 4] = sc.d1_cau;
      end
      if (sc.d2_en && n == int'(sc.d2_cyc)) begin
        det_trap[sc.d2_stg] = 1'b1; det_cause[sc.d2_stg*4 +: 4] = sc.d2_cau;
      end
      irq = sc.irq_en && n >= int'(sc.irq_lo) && n <= int'(sc.irq_hi);
      #1;
      if (n == hold_cyc) begin
        chk(stage_hold == mask, $sformatf("R4 scn%0d stage_hold", s), 64'(stage_hold), 64'(mask));
        chk(!in_ready, $sformatf("R4 scn%0d in_ready", s), 64'(in_ready), 64'd0);
      end
      if (wb_valid) begin
        if (first_wb < 0) first_wb = n;
        if (wb_pc != BASE + 32'(4 * commits)) seq_bad++;
        commits++;
      end
      if (redir_valid) begin
        got = 1; rpc = redir_pc; redir_cyc = n;
      end
      if (in_ready) fcount++;
      @(negedge clk);
    end
    in_valid = 1'b0; det_trap = '0; det_cause = '0; irq = 1'b0;
    #1;
    chk(got == sc.exp_redir, $sformatf("R10 scn%0d entry occurrence", s), 64'(got), 64'(sc.exp_redir));
    chk(commits == int'(sc.exp_commits), $sformatf("R3 scn%0d commits before entry", s),
        64'(commits), 64'(sc.exp_commits));
    chk(seq_bad == 0, $sformatf("R2 scn%0d commit order", s), 64'(seq_bad), 64'd0);
    if (sc.exp_commits != 0)
      chk(first_wb == NS, $sformatf("R2 scn%0d first commit cycle", s), 64'(first_wb), 64'(NS));
    if (sc.exp_redir && got) begin
      if (sc.exp_trap) begin
        a1 = int'(sc.d1_cyc) + NS - 1 - int'(sc.d1_stg);
        a2 = sc.d2_en ? int'(sc.d2_cyc) + NS - 1 - int'(sc.d2_stg) : a1;
        exp_cyc = (a2 < a1) ? a2 : a1;
        chk(rpc == TV, $sformatf("R5 R11 scn%0d trap vector", s), 64'(rpc), 64'(TV));
        chk(redir_cyc == exp_cyc, $sformatf("R3 R8 scn%0d entry cycle", s), 64'(redir_cyc), 64'(exp_cyc));
      end else begin
        exp_cyc = (int'(sc.irq_lo) > NS) ? int'(sc.irq_lo) : NS;
        chk(rpc == IV, $sformatf("R9 scn%0d irq vector", s), 64'(rpc), 64'(IV));
        chk(redir_cyc == exp_cyc, $sformatf("R9 scn%0d entry cycle", s), 64'(redir_cyc), 64'(exp_cyc));
      end
      chk(epc == BASE + 32'(4 * int'(sc.exp_epc)), $sformatf("R6 scn%0d epc", s),
          64'(epc), 64'(BASE + 32'(4 * int'(sc.exp_epc))));
      chk(cause == sc.exp_cause, $sformatf("R6 R8 scn%0d cause", s), 64'(cause), 64'(sc.exp_cause));
      repeat (6) begin
        if (wb_valid) quiet++;
        @(negedge clk); #1;
      end
      chk(quiet == 0, $sformatf("R7 scn%0d younger discarded", s), 64'(quiet), 64'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired (R1..all) actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_pc = '0; det_trap = '0; det_cause = '0; irq = 1'b0;
    for (int s = 0; s < NSCN; s++) run_scn(s);
    // directed: reset clears saved state left by the last entry
    do_reset();
    #1;
    chk(epc == 32'd0, "R1 epc after reset", 64'(epc), 64'd0);
    chk(cause == 4'd0, "R1 cause after reset", 64'(cause), 64'd0);
    chk(!wb_valid && !redir_valid, "R1 no commit or entry", 64'({wb_valid, redir_valid}), 64'd0);
    chk(in_ready && stage_hold == '0, "R1 fetch open, no hold",
        64'({in_ready, stage_hold}), 64'h10);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule